// File: doc/BRIEF.md
# DMA Request Qualifier and Priority Arbiter

This block sits in front of a DMA transfer engine. It collects a single-request line and a burst-request line from the peripheral behind each channel, and a software request for each channel. Each channel's requests are qualified against its control settings: enable, peripheral-request mask, burst-only and high priority. The block then picks one channel to hand to the engine. The grant is a registered one-cycle strobe carrying the channel index. A grant is only issued while the engine reports that it is idle.

Software requests are held in a pending vector. When the engine reports completion of a channel, the block clears that channel's pending bit. The block also drives a registered per-channel status vector. It marks the channels that are enabled, accept peripheral requests and are currently waiting for their peripheral to raise a request.

A channel that has been granted is not granted again until its combined request has been seen low for at least one cycle. This keeps a level-held request from turning into a stream of grants.

Top module: `dma_req_arbiter`

## Requirements
- R1: When a channel's `req_mask` bit is 1, that channel's peripheral single and burst lines produce no grant. A software request set through `sw_req_set` still produces a grant for that channel.
- R2: When a channel's `burst_only` bit is 1, its `periph_single` line produces no grant. Its `periph_burst` line does produce a grant.
- R3: A `sw_req_set` pulse sets the channel's bit in `sw_pending` at the next clock edge. A `done_valid` pulse with `done_ch` equal to that channel clears the bit at the next clock edge.
- R4: A channel whose `ch_enable` bit is 0 is never granted, whatever its requests are.
- R5: When any eligible channel has its `high_prio` bit set to 1, the grant goes to a high-priority channel ahead of every default-priority channel.
- R6: `wait_status[i]` is 1, one cycle after the inputs, exactly when `master_en` is 1, channel i is enabled, its mask is 0, and its qualified peripheral request is low.
- R7: Among eligible channels of the same priority group, the lowest channel index wins.
- R8: `grant_valid` is asserted for one cycle, with `grant_ch`, only in the cycle after a cycle in which `engine_idle` was 1. A granted channel is not granted again until its combined request has been observed low.
- R9: While `master_en` is 0, no grant is issued and `wait_status` reads all zeros.
- R10: After reset, `grant_valid` is 0, `wait_status` is all zeros and `sw_pending` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Global enable for arbitration and status |
| ch_enable | input | NCH | Per-channel enable |
| req_mask | input | NCH | Per-channel peripheral-request mask |
| burst_only | input | NCH | Per-channel: ignore single requests |
| high_prio | input | NCH | Per-channel high-priority flag |
| periph_single | input | NCH | Peripheral single-request lines |
| periph_burst | input | NCH | Peripheral burst-request lines |
| sw_req_set | input | NCH | Pulse: set software request for channel |
| engine_idle | input | 1 | Transfer engine can accept a grant |
| done_valid | input | 1 | Completion pulse from the engine |
| done_ch | input | IDXW | Channel index of the completion |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_ch | output | IDXW | Granted channel index |
| wait_status | output | NCH | Channels waiting on their peripheral |
| sw_pending | output | NCH | Outstanding software requests |

## Verification
A corrupted re-arm bit would show at the ports as a missing or duplicated grant on the next idle cycle. The bench catches this because it holds requests high across several idle pulses. A fault in the qualification terms would show as a wrong `grant_ch` one cycle after the idle pulse, or as a grant appearing where the scoreboard expects none. A stuck pending bit would show in `sw_pending` on the cycle after the completion pulse. A bad status term would show in `wait_status` one cycle after its inputs settle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Index of the lowest set bit; returns 0 when none is set.
  function automatic int unsigned lowest_set(input logic [63:0] vec, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (vec[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_req_qual.sv
module dma_req_qual #(
  parameter int NCH = 32
) (
  input  logic [NCH-1:0] ch_enable,
  input  logic [NCH-1:0] req_mask,
  input  logic [NCH-1:0] burst_only,
  input  logic [NCH-1:0] periph_single,
  input  logic [NCH-1:0] periph_burst,
  output logic [NCH-1:0] hw_req,
  output logic [NCH-1:0] waiting
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic line_req;
    assign line_req   = periph_burst[i] | (periph_single[i] & ~burst_only[i]);
    assign hw_req[i]  = line_req & ~req_mask[i];
    assign waiting[i] = ch_enable[i] & ~req_mask[i] & ~line_req;
  end
endmodule

// File: rtl/dma_sw_bank.sv
module dma_sw_bank #(
  parameter int NCH  = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  set_vec,
  input  logic            done_valid,
  input  logic [IDXW-1:0] done_ch,
  output logic [NCH-1:0]  pending
);
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};
  logic [NCH-1:0] clr_vec;
  assign clr_vec = done_valid ? (ONE << done_ch) : '0;

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= (pending & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH  = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic [NCH-1:0]  eligible,
  input  logic [NCH-1:0]  high_prio,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  import dma_arb_pkg::*;
  logic [NCH-1:0] hi_set;
  logic [NCH-1:0] pool;
  logic [63:0]    wide;

  assign hi_set = eligible & high_prio;
  assign pool   = (|hi_set) ? hi_set : eligible;
  assign any    = |eligible;

  always_comb begin
    wide = '0;
    wide[NCH-1:0] = pool;
    idx = IDXW'(lowest_set(wide, NCH));
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH  = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            master_en,
  input  logic [NCH-1:0]  ch_enable,
  input  logic [NCH-1:0]  req_mask,
  input  logic [NCH-1:0]  burst_only,
  input  logic [NCH-1:0]  high_prio,
  input  logic [NCH-1:0]  periph_single,
  input  logic [NCH-1:0]  periph_burst,
  input  logic [NCH-1:0]  sw_req_set,
  input  logic            engine_idle,
  input  logic            done_valid,
  input  logic [IDXW-1:0] done_ch,
  output logic            grant_valid,
  output logic [IDXW-1:0] grant_ch,
  output logic [NCH-1:0]  wait_status,
  output logic [NCH-1:0]  sw_pending
);
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  logic [NCH-1:0]  hw_req, waiting, raw_req, armed, eligible, take_vec;
  logic            pick_any, issue;
  logic [IDXW-1:0] pick_idx;

  dma_req_qual #(.NCH(NCH)) u_qual (
    .ch_enable(ch_enable), .req_mask(req_mask), .burst_only(burst_only),
    .periph_single(periph_single), .periph_burst(periph_burst),
    .hw_req(hw_req), .waiting(waiting)
  );

  dma_sw_bank #(.NCH(NCH), .IDXW(IDXW)) u_sw (
    .clk(clk), .rst(rst), .set_vec(sw_req_set),
    .done_valid(done_valid), .done_ch(done_ch), .pending(sw_pending)
  );

  assign raw_req  = hw_req | sw_pending;
  assign eligible = raw_req & armed & ch_enable & {NCH{master_en}};

  dma_prio_pick #(.NCH(NCH), .IDXW(IDXW)) u_pick (
    .eligible(eligible), .high_prio(high_prio), .any(pick_any), .idx(pick_idx)
  );

  assign issue    = engine_idle & pick_any;
  assign take_vec = issue ? (ONE << pick_idx) : '0;

  // A channel re-arms once its combined request is seen low.
  always_ff @(posedge clk) begin
    if (rst) armed <= '1;
    else     armed <= (armed | ~raw_req) & ~take_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_ch    <= '0;
      wait_status <= '0;
    end else begin
      grant_valid <= issue;
      grant_ch    <= issue ? pick_idx : grant_ch;
      wait_status <= master_en ? waiting : '0;
    end
  end
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NCH  = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst,
  input logic            master_en,
  input logic [NCH-1:0]  ch_enable,
  input logic [NCH-1:0]  req_mask,
  input logic            engine_idle,
  input logic            grant_valid,
  input logic [IDXW-1:0] grant_ch,
  input logic [NCH-1:0]  wait_status,
  input logic [NCH-1:0]  sw_pending
);
  logic [NCH-1:0] en_q, mask_q, swp_q;
  logic           live;
  always_ff @(posedge clk) begin
    en_q   <= ch_enable;
    mask_q <= req_mask;
    swp_q  <= sw_pending;
    live   <= !rst;
  end

  // R4: granted channel was enabled in the deciding cycle
  p_grant_enabled_r4: assert property (@(posedge clk) disable iff (rst || !live)
    grant_valid |-> en_q[grant_ch]);
  // R9: master enable low silences grants and status
  p_master_off_r9: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> (!grant_valid && wait_status == '0));
  // R8: grants follow an idle cycle only
  p_idle_only_r8: assert property (@(posedge clk) disable iff (rst || !live)
    grant_valid |-> $past(engine_idle));
  // R8: no immediate re-grant of the same channel
  p_no_regrant_r8: assert property (@(posedge clk) disable iff (rst)
    grant_valid |=> !(grant_valid && grant_ch == $past(grant_ch)));
  // R1: a masked channel is granted only with software pending
  p_mask_sw_r1: assert property (@(posedge clk) disable iff (rst || !live)
    grant_valid |-> (!mask_q[grant_ch] || swp_q[grant_ch]));
endmodule

bind dma_req_arbiter dma_arb_chk #(.NCH(NCH), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .master_en(master_en), .ch_enable(ch_enable),
  .req_mask(req_mask), .engine_idle(engine_idle), .grant_valid(grant_valid),
  .grant_ch(grant_ch), .wait_status(wait_status), .sw_pending(sw_pending)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int NCH = 32;
  localparam int IDXW = 5;

  logic clk = 0, rst = 1;
  logic master_en = 0, engine_idle = 0, done_valid = 0;
  logic [NCH-1:0] ch_enable = '0, req_mask = '0, burst_only = '0, high_prio = '0;
  logic [NCH-1:0] periph_single = '0, periph_burst = '0, sw_req_set = '0;
  logic [IDXW-1:0] done_ch = '0;
  logic grant_valid;
  logic [IDXW-1:0] grant_ch;
  logic [NCH-1:0] wait_status, sw_pending;

  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  bit done_flag = 0;

  always #4 clk = ~clk; // 125 MHz

  dma_req_arbiter #(.NCH(NCH)) i_dma_req_arbiter (.*);

  // Monitor: compare every grant with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && grant_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected grant: actual ch %0d expected none (R8/R1/R2/R4/R9)", grant_ch);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (grant_ch != IDXW'(e)) begin
          n_fail++;
          $display("FAIL %s: grant actual ch %0d expected ch %0d", t, grant_ch, e);
        end
      end
    end
  end

  task automatic expect_grant(input int ch, input string t);
    exp_q.push_back(ch);
    tag_q.push_back(t);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pulse();
    engine_idle = 1;
    tick(1);
    engine_idle = 0;
    tick(1);
  endtask

  task automatic drained(input string t);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: missing grant, actual none expected ch %0d", t, exp_q[0]);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic check_vec(input string t, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic clear_reqs();
    periph_single = '0;
    periph_burst = '0;
    req_mask = '0;
    burst_only = '0;
    high_prio = '0;
    tick(2);
  endtask

  initial begin
    fork
      begin
        tick(3);
        // R10: reset state
        check_vec("R10 grant_valid", {31'b0, grant_valid}, '0);
        check_vec("R10 wait_status", wait_status, '0);
        check_vec("R10 sw_pending", sw_pending, '0);
        rst = 0;
        tick(1);

        // R9: master disabled
        ch_enable = 32'h0000_00FF;
        periph_single[3] = 1;
        tick(1);
        idle_pulse();
        drained("R9 no grant");
        check_vec("R9 wait zero", wait_status, '0);

        // R6: status with master enabled
        master_en = 1;
        tick(1);
        check_vec("R6 wait_status", wait_status, 32'h0000_00F7);

        // R7 and R8: lowest index first, no re-grant while held
        periph_single[5] = 1;
        tick(1);
        expect_grant(3, "R7 lowest index");
        idle_pulse();
        drained("R7");
        expect_grant(5, "R8 next channel");
        idle_pulse();
        drained("R8");
        idle_pulse();
        drained("R8 held request not regranted");
        clear_reqs();

        // R8: no grant without idle
        periph_single[2] = 1;
        tick(3);
        drained("R8 idle low");

        // R5: priority group
        periph_single[6] = 1;
        high_prio[6] = 1;
        tick(1);
        expect_grant(6, "R5 high priority first");
        idle_pulse();
        drained("R5");
        expect_grant(2, "R5 default after");
        idle_pulse();
        drained("R5 b");
        clear_reqs();

        // R2: burst-only
        burst_only[1] = 1;
        periph_single[1] = 1;
        tick(1);
        idle_pulse();
        drained("R2 single ignored");
        periph_burst[1] = 1;
        tick(1);
        expect_grant(1, "R2 burst accepted");
        idle_pulse();
        drained("R2");
        clear_reqs();

        // R1 and R3: masked channel, software request
        req_mask[4] = 1;
        periph_single[4] = 1;
        tick(1);
        idle_pulse();
        drained("R1 masked peripheral ignored");
        sw_req_set[4] = 1;
        tick(1);
        sw_req_set = '0;
        check_vec("R3 pending set", sw_pending, 32'h0000_0010);
        expect_grant(4, "R1 software start");
        idle_pulse();
        drained("R1");
        done_ch = 5'd4;
        done_valid = 1;
        tick(1);
        done_valid = 0;
        check_vec("R3 pending cleared", sw_pending, '0);
        clear_reqs();

        // R4: disabled channel
        periph_single[9] = 1;
        tick(1);
        idle_pulse();
        idle_pulse();
        drained("R4 disabled channel");
        clear_reqs();
      end
      begin
        repeat (5000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion (all)");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule